// File: doc/BRIEF.md
# DDR Luma/Chroma Output Interleaver

This block takes one 20-bit video word per pixel and sends it out on a 10-bit bus. Each word holds a 10-bit luma sample and a 10-bit chroma sample, with the chroma alternating between the blue and red colour-difference components from one word to the next. The luma sample goes out first and the chroma sample second. A forwarded clock travels with the data so that a receiver can capture it. In double-edge mode, that clock runs at half the bus transition rate: the receiver captures luma on the rising edge and chroma on the falling edge. As an example, a 148.5 MHz forwarded clock carries 297 Mb/s on each data line.

The block runs on an internal clock that is four times the forwarded-clock rate. Each word therefore occupies four ticks, called slots, and a slot sequencer walks through them. The sequencer starts in `ST_IDLE` after reset and takes the *start* transition into `ST_Y_LEAD`. From there it cycles through `ST_Y_LEAD` → `ST_Y_TAIL` (*luma hold*), `ST_Y_TAIL` → `ST_C_LEAD` (*swap to chroma*), `ST_C_LEAD` → `ST_C_TAIL` (*chroma hold*) and `ST_C_TAIL` → `ST_Y_LEAD` (*word boundary*). Taking a word from the input, switching mode and switching clock phase all happen only on the *start* and *word boundary* transitions.

Double-edge mode is used only when the link-rate input reports the top rate. At every other rate the block falls back to a single-edge mode, where the clock pulses once per 10-bit sample. A small register holds two controls. One is the phase select, which chooses between a nominal and a quadrature (90°) forwarded clock. The other is a 5-bit fine-delay code, which the block only stores and passes to an external delay line with steps of roughly 40 ps, up to about 1.2 ns.

Top module: `ddr_lc_serializer`

## Requirements
- R1: While reset is asserted, `bus_data` is 0, `fwd_clk` is low, `dly_fine` is 0 and a read of the delay-control address returns 0. The first rising edge after reset is released enters `ST_Y_LEAD`.
- R2: Call the slot entered on the word-boundary edge tick 0, followed by ticks 1, 2 and 3. `bus_data` carries the word's luma during ticks 0–1 and its chroma during ticks 2–3. The bus therefore changes exactly every two ticks.
- R3: The data inputs are sampled only on the edge that enters tick 0. Changes to `in_valid`, `in_luma` or `in_chroma` during ticks 0–3 do not affect the word currently being sent.
- R4: If `in_valid` is low at the word boundary, the word sent is the blanking pair: luma 0x040, then chroma 0x200.
- R5: In double-edge mode with phase select 0 (nominal), `fwd_clk` is high in ticks 1–2 and low in ticks 3 and 0. Its rising edge falls in the middle of the luma sample and its falling edge in the middle of the chroma sample.
- R6: In double-edge mode with phase select 1 (quadrature), `fwd_clk` is high in ticks 2–3 and low in ticks 0–1. This is a shift of one tick, or 90°.
- R7: Double-edge mode is used only when `rate_code` equals 2, the top rate. For codes 0, 1 and 3, `fwd_clk` is high in ticks 1 and 3 only, which is one rising edge per sample, and the phase select has no effect.
- R8: The delay-control register sits at address 0x6C. Bit 5 is the phase select and bits 4:0 are the fine code. `dly_fine` shows bits 4:0 on the tick after a write. `cfg_rdata` returns the full register when `cfg_addr` is 0x6C and returns 0 for any other address.
- R9: A write with `cfg_addr` other than 0x6C changes neither the register nor any output.
- R10: `rate_code` and the phase select are taken only at the word boundary, so a change in the middle of a word takes effect from the next word. In double-edge mode, every high pulse of `fwd_clk` lasts at least two ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, four times the forwarded-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is present at the word boundary |
| in_luma | input | 10 | Luma half of the input word |
| in_chroma | input | 10 | Chroma half of the input word (blue and red difference alternating) |
| rate_code | input | 2 | Link rate; 2 selects the top rate |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 6 | Register write data |
| cfg_rdata | output | 6 | Register read data, decoded from `cfg_addr` |
| bus_data | output | 10 | Interleaved output bus |
| fwd_clk | output | 1 | Forwarded clock |
| dly_fine | output | 5 | Fine-delay code for the external delay line |

## Verification
A wrong sequencer state shows up at the ports almost at once. The bus changes value at the wrong tick, or the chroma slot repeats the luma value, within four ticks of the error. A stale mode flag or phase flag shifts the position of `fwd_clk`'s high ticks within the very next word, so checking the clock level on every tick of every word catches it at once. A register that decodes the wrong address, or that latches phase in the middle of a word, shows up either in the readback made after each word or in the clock pattern of the following word.

// File: rtl/ddr_lc_pkg.sv
package ddr_lc_pkg;

    // Slot sequencer states; each word occupies the four non-idle slots.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_Y_LEAD,
        ST_Y_TAIL,
        ST_C_LEAD,
        ST_C_TAIL
    } slot_e;

    // Forwarded-clock level for the slot being entered.
    function automatic logic fclk_level(slot_e s, logic ddr, logic quad);
        logic lvl;
        lvl = 1'b0;
        unique case (s)
            ST_IDLE:   lvl = 1'b0;
            ST_Y_LEAD: lvl = 1'b0;
            ST_Y_TAIL: lvl = !(ddr && quad);
            ST_C_LEAD: lvl = ddr;
            ST_C_TAIL: lvl = !(ddr && !quad);
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/ddr_lc_cfg.sv
module ddr_lc_cfg #(
    parameter int AW = 8,
    parameter int FINE_W = 5,
    parameter logic [AW-1:0] REG_ADDR = 8'h6C,
    localparam int REG_W = FINE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              quad_sel,
    output logic [FINE_W-1:0] fine_code
);

    logic [REG_W-1:0] reg_q;
    logic             hit;

    assign hit = (addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (we && hit) begin
            reg_q <= wdata;
        end
    end

    assign rdata     = hit ? reg_q : '0;
    assign quad_sel  = reg_q[FINE_W];
    assign fine_code = reg_q[FINE_W-1:0];

endmodule

// File: rtl/ddr_lc_fsm.sv
module ddr_lc_fsm
    import ddr_lc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot_q,
    output slot_e slot_d
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= ST_IDLE;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_comb begin
        slot_d = ST_IDLE;
        unique case (slot_q)
            ST_IDLE:   slot_d = ST_Y_LEAD;   // start
            ST_Y_LEAD: slot_d = ST_Y_TAIL;   // luma hold
            ST_Y_TAIL: slot_d = ST_C_LEAD;   // swap to chroma
            ST_C_LEAD: slot_d = ST_C_TAIL;   // chroma hold
            ST_C_TAIL: slot_d = ST_Y_LEAD;   // word boundary
        endcase
    end

endmodule

// File: rtl/ddr_lc_lane.sv
module ddr_lc_lane
    import ddr_lc_pkg::*;
#(
    parameter int DW = 10,
    parameter int RATE_W = 2,
    parameter int RATE_TOP = 2,
    parameter logic [DW-1:0] BLANK_Y = 10'h040,
    parameter logic [DW-1:0] BLANK_C = 10'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot_d,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_luma,
    input  logic [DW-1:0]     in_chroma,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              quad_sel,
    output logic [DW-1:0]     bus_data,
    output logic              fwd_clk,
    output logic              ddr_act,
    output logic              quad_act
);

    logic          boundary;
    logic          ddr_nx;
    logic          quad_nx;
    logic [DW-1:0] chroma_q;

    assign boundary = (slot_d == ST_Y_LEAD);
    assign ddr_nx   = boundary ? (rate_code == RATE_W'(RATE_TOP)) : ddr_act;
    assign quad_nx  = boundary ? quad_sel : quad_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ddr_act  <= 1'b0;
            quad_act <= 1'b0;
            fwd_clk  <= 1'b0;
            bus_data <= '0;
            chroma_q <= '0;
        end else begin
            ddr_act  <= ddr_nx;
            quad_act <= quad_nx;
            fwd_clk  <= fclk_level(slot_d, ddr_nx, quad_nx);
            unique case (slot_d)
                ST_Y_LEAD: begin
                    bus_data <= in_valid ? in_luma : BLANK_Y;
                    chroma_q <= in_valid ? in_chroma : BLANK_C;
                end
                ST_C_LEAD: bus_data <= chroma_q;
                ST_IDLE, ST_Y_TAIL, ST_C_TAIL: ;
            endcase
        end
    end

endmodule

// File: rtl/ddr_lc_serializer.sv
module ddr_lc_serializer
    import ddr_lc_pkg::*;
#(
    parameter int DW = 10,
    parameter int AW = 8,
    parameter int FINE_W = 5,
    parameter int RATE_W = 2,
    parameter int RATE_TOP = 2,
    parameter logic [AW-1:0] REG_ADDR = 8'h6C,
    parameter logic [DW-1:0] BLANK_Y = 10'h040,
    parameter logic [DW-1:0] BLANK_C = 10'h200,
    localparam int REG_W = FINE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_luma,
    input  logic [DW-1:0]     in_chroma,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [DW-1:0]     bus_data,
    output logic              fwd_clk,
    output logic [FINE_W-1:0] dly_fine
);

    slot_e slot_q;
    slot_e slot_d;
    logic  quad_sel;
    logic  ddr_act;
    logic  quad_act;

    ddr_lc_cfg #(
        .AW(AW), .FINE_W(FINE_W), .REG_ADDR(REG_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .quad_sel(quad_sel), .fine_code(dly_fine)
    );

    ddr_lc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .slot_d(slot_d)
    );

    ddr_lc_lane #(
        .DW(DW), .RATE_W(RATE_W), .RATE_TOP(RATE_TOP),
        .BLANK_Y(BLANK_Y), .BLANK_C(BLANK_C)
    ) u_lane (
        .clk(clk), .rst_n(rst_n), .slot_d(slot_d),
        .in_valid(in_valid), .in_luma(in_luma), .in_chroma(in_chroma),
        .rate_code(rate_code), .quad_sel(quad_sel),
        .bus_data(bus_data), .fwd_clk(fwd_clk),
        .ddr_act(ddr_act), .quad_act(quad_act)
    );

endmodule

// File: rtl/ddr_lc_serializer_chk.sv
module ddr_lc_serializer_chk
    import ddr_lc_pkg::*;
#(
    parameter int DW = 10,
    parameter int AW = 8,
    parameter int FINE_W = 5,
    parameter logic [AW-1:0] REG_ADDR = 8'h6C,
    parameter logic [DW-1:0] BLANK_Y = 10'h040,
    localparam int REG_W = FINE_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              cfg_we,
    input logic [AW-1:0]     cfg_addr,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [DW-1:0]     bus_data,
    input logic              fwd_clk,
    input logic [FINE_W-1:0] dly_fine,
    input slot_e             slot_q,
    input logic              quad_sel,
    input logic              ddr_act,
    input logic              quad_act
);

    assert_luma_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == ST_Y_TAIL) |-> $stable(bus_data));

    assert_chroma_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == ST_C_TAIL) |-> $stable(bus_data));

    assert_blank_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q == ST_C_TAIL || slot_q == ST_IDLE) && !in_valid) |=> (bus_data == BLANK_Y));

    assert_nominal_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fwd_clk) && ddr_act && !quad_act) |-> (slot_q == ST_Y_TAIL));

    assert_quad_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fwd_clk) && ddr_act && quad_act) |-> (slot_q == ST_C_LEAD));

    assert_single_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_act && (slot_q == ST_Y_TAIL || slot_q == ST_C_TAIL)) |-> fwd_clk);

    assert_reg_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_ADDR) |=> (dly_fine == $past(cfg_wdata[FINE_W-1:0])));

    assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != REG_ADDR) |=> ($stable(dly_fine) && $stable(quad_sel)));

    assert_boundary_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != ST_Y_LEAD) |-> ($stable(ddr_act) && $stable(quad_act)));

    assert_no_runt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ddr_act && $rose(fwd_clk)) |=> fwd_clk);

endmodule

bind ddr_lc_serializer ddr_lc_serializer_chk #(
    .DW(DW), .AW(AW), .FINE_W(FINE_W), .REG_ADDR(REG_ADDR), .BLANK_Y(BLANK_Y)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_data(bus_data), .fwd_clk(fwd_clk), .dly_fine(dly_fine),
    .slot_q(slot_q), .quad_sel(quad_sel),
    .ddr_act(ddr_act), .quad_act(quad_act)
);

// File: tb/ddr_lc_serializer_test.sv
`timescale 1ns/100ps
module ddr_lc_serializer_test;

    localparam logic [7:0] ADDR = 8'h6C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_luma = '0;
    logic [9:0] in_chroma = '0;
    logic [1:0] rate_code = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = ADDR;
    logic [5:0] cfg_wdata = '0;
    logic [5:0] cfg_rdata;
    logic [9:0] bus_data;
    logic       fwd_clk;
    logic [4:0] dly_fine;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] model_reg = '0;

    always #2 clk = ~clk;

    ddr_lc_serializer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_luma(in_luma), .in_chroma(in_chroma), .rate_code(rate_code),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_data(bus_data), .fwd_clk(fwd_clk),
        .dly_fine(dly_fine)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Called at a falling edge just before a word boundary edge.
    task automatic send_word(input bit v, input logic [9:0] y, input logic [9:0] c,
                             input logic [1:0] rt, input bit wr,
                             input logic [7:0] wa, input logic [5:0] wd);
        bit ddr;
        bit quad;
        logic [9:0] ey;
        logic [9:0] ec;
        in_valid  = v;
        in_luma   = y;
        in_chroma = c;
        rate_code = rt;
        ddr  = (rt == 2'd2);
        quad = model_reg[5];
        ey   = v ? y : 10'h040;
        ec   = v ? c : 10'h200;
        for (int t = 0; t < 4; t++) begin
            bit efc;
            @(negedge clk);
            if (!ddr)      efc = (t == 1 || t == 3);
            else if (quad) efc = (t >= 2);
            else           efc = (t == 1 || t == 2);
            // R2 luma then chroma, R4 blanking
            chk(bus_data == (t < 2 ? ey : ec), v ? "R2 bus data" : "R4 blank data",
                int'(bus_data), int'(t < 2 ? ey : ec));
            // R5 nominal, R6 quadrature, R7 single-edge
            chk(fwd_clk == efc, !ddr ? "R7 sdr clock" : (quad ? "R6 quad clock" : "R5 nominal clock"),
                int'(fwd_clk), int'(efc));
            if (t == 0) begin
                // R3 / R10: scramble inputs mid-word
                in_valid  = !v;
                in_luma   = ~y;
                in_chroma = ~c;
                rate_code = ~rt;
                if (wr) begin
                    cfg_we    = 1'b1;
                    cfg_addr  = wa;
                    cfg_wdata = wd;
                end
            end
            if (t == 1) begin
                cfg_we   = 1'b0;
                cfg_addr = ADDR;
            end
        end
        if (wr && wa == ADDR) model_reg = wd;
        chk(dly_fine == model_reg[4:0], "R8 fine code out", int'(dly_fine), int'(model_reg[4:0]));
        cfg_addr = ADDR;
        #0.5;
        chk(cfg_rdata == model_reg, wr && wa != ADDR ? "R9 readback" : "R8 readback",
            int'(cfg_rdata), int'(model_reg));
        cfg_addr = ADDR + 8'd1;
        #0.5;
        chk(cfg_rdata == 6'd0, "R8 other address reads zero", int'(cfg_rdata), 0);
        cfg_addr = ADDR;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_data == 10'd0, "R1 reset data", int'(bus_data), 0);
        chk(fwd_clk == 1'b0, "R1 reset clock", int'(fwd_clk), 0);
        chk(dly_fine == 5'd0, "R1 reset fine", int'(dly_fine), 0);
        chk(cfg_rdata == 6'd0, "R1 reset register", int'(cfg_rdata), 0);
        rst_n = 1'b1;
        // Sweep: rate x phase x valid, fine codes 0..31, some foreign writes
        for (int i = 0; i < 64; i++) begin
            logic [5:0] wd;
            logic [7:0] wa;
            logic [9:0] y;
            logic [9:0] c;
            int nxt;
            nxt = i + 1;
            wd  = {nxt[3], i[4:0]};
            wa  = (i % 7 == 6) ? ADDR + 8'd3 : ADDR;   // R9 foreign writes
            y   = 10'((i * 37 + 5) & 32'h3FF);
            c   = 10'(((i % 2) != 0 ? 32'h300 : 32'h100) + i);
            send_word(!i[2] || i[5], y, c, i[1:0], 1'b1, wa, wd);
        end
        // Back-to-back DDR words, no writes, both phases covered above
        for (int i = 0; i < 8; i++) begin
            send_word(1'b1, 10'(i * 100), 10'(1023 - i * 90), 2'd2, 1'b0, ADDR, 6'd0);
        end
        summary();
    end

endmodule